// File: doc/BRIEF.md
# Cache-line burst alignment controller

This block decides how many dwords each bus-master transaction moves. When a transfer starts it works out an effective line size from an 8-bit line-size setting and a programmed maximum burst length, and it keeps that size for the whole transfer. It then follows the running address. While the address sits inside a line, it issues one dword per transaction. Once the address lands on a line boundary, it issues whole-line bursts. No transaction is ever longer than the work that remains.

For a memory-to-memory move the block compares the read and write start addresses against the line size. If they sit at different byte offsets inside their lines, the move runs in fallback mode. In that mode every transaction uses the maximum burst length and no boundary is tracked. The block also picks a read and a write command kind for each transaction, based on three enables that are sampled at start. The bus signalling itself is outside this block. A master asserts `xfer_done` when the offered transaction has completed, and the block then offers the next one.

Top module: `burst_align_ctrl`

## Requirements
- R1: The effective line size in dwords is the smaller of two values. The first is the maximum burst, given by `max_burst_sel`: 0 selects 2 dwords, 1 selects 4, 2 selects 8 and 3 selects 16. The second is the line-size setting rounded down to 2, 4, 8 or 16, where settings 1 to 3 count as 2 and settings of 16 or more count as 16.
- R2: A line-size setting of zero makes the effective line size equal to the maximum burst.
- R3: In aligned mode, when the current address is not on an effective-line boundary (the address modulo line bytes, where line bytes is dwords × 4, is not zero), `req_dwords` is 1.
- R4: In aligned mode, when the current address is on a boundary, `req_dwords` is the smaller of the line size and the remaining dwords.
- R5: A move whose source and destination byte offsets within a line differ runs with `align_mode` = 0, and every transaction in it moves the smaller of the maximum burst and the remaining dwords. A move whose offsets are equal runs with `align_mode` = 1.
- R6: A single-address transfer (`start_move` = 0) always runs with `align_mode` = 1.
- R7: The transfer length is `byte_count` / 4 dwords. A transaction never moves more dwords than remain. `req_valid` drops in the cycle after the last transaction completes. A zero length raises no request at all.
- R8: Each completed transaction advances `req_addr` and `req_dst_addr` by 4 × `req_dwords` bytes.
- R9: A `start` that arrives while `req_valid` is 1 is ignored. The offered transaction does not change until `xfer_done` is asserted.
- R10: `req_rd_cmd` is 0 (none) for single writes. Otherwise it is 2 (line read) for an aligned, full-line transaction at a boundary when the line-read enable is set. Failing that, it is 3 (multiple read) when the transaction is longer than one dword and the multiple-read enable is set. In all other cases it is 1 (plain read).
- R11: `req_wr_cmd` is 0 (none) for single reads. Otherwise it is 2 (write-and-invalidate) for an aligned, full-line transaction at a boundary when the invalidate enable is set, and 1 (plain write) in all other cases.
- R12: After reset, and whenever no transfer is active, `req_valid`, `req_dwords`, `req_rd_cmd` and `req_wr_cmd` are 0. `align_mode` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_size_cfg | input | 8 | Line-size setting in dwords, sampled at start |
| max_burst_sel | input | 2 | Maximum burst code (2, 4, 8, 16 dwords), sampled at start |
| en_line_read | input | 1 | Allows the line-read command |
| en_multi_read | input | 1 | Allows the multiple-read command |
| en_write_inval | input | 1 | Allows the write-and-invalidate command |
| start | input | 1 | Begins a transfer when idle |
| start_move | input | 1 | Transfer is a memory-to-memory move |
| start_write | input | 1 | Single transfer is a write (ignored for moves) |
| src_addr | input | ADDR_W | Transfer address (read side of a move) |
| dst_addr | input | ADDR_W | Write-side address of a move |
| byte_count | input | CNT_W | Transfer length in bytes |
| xfer_done | input | 1 | Offered transaction has completed |
| req_valid | output | 1 | A transaction is offered |
| req_dwords | output | 5 | Dwords in the offered transaction |
| req_addr | output | ADDR_W | Current primary address |
| req_dst_addr | output | ADDR_W | Current write-side address of a move |
| req_rd_cmd | output | 2 | Read command kind |
| req_wr_cmd | output | 2 | Write command kind |
| align_mode | output | 1 | 1 when boundary tracking is active |

## Verification
Some properties hold on every cycle, and the assertions check those. An offered size is never zero and never exceeds what remains. In aligned mode it is never wider than a line, and it is a single dword off a boundary. A line read only appears at a boundary. The offer holds steady until completion, the address steps by the completed size, and the request lines are quiet while idle. Other behaviour needs the bench's scenarios to show it. These are the values themselves: the rounding and minimum of the line size, the fallback choice for moves with unequal offsets, the zero-length case, the ignored restart, and the exact command sequence across a misaligned start.

// File: rtl/burst_align_pkg.sv
package burst_align_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_PLAIN = 2'd1,
    RD_LINE  = 2'd2,
    RD_MULTI = 2'd3
  } rd_cmd_e;

  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_PLAIN = 2'd1,
    WR_INVAL = 2'd2
  } wr_cmd_e;

  // log2 of the setting rounded down to 2/4/8/16 dwords
  function automatic logic [2:0] round_line_log(input logic [7:0] cfg);
    if (cfg >= 8'd16)     return 3'd4;
    else if (cfg >= 8'd8) return 3'd3;
    else if (cfg >= 8'd4) return 3'd2;
    else                  return 3'd1;
  endfunction

  function automatic logic [2:0] burst_log(input logic [1:0] sel);
    return {1'b0, sel} + 3'd1;
  endfunction

  function automatic logic [2:0] effective_log(input logic [7:0] cfg, input logic [1:0] sel);
    logic [2:0] m;
    logic [2:0] r;
    m = burst_log(sel);
    if (cfg == 8'd0) return m;
    r = round_line_log(cfg);
    return (r < m) ? r : m;
  endfunction

  function automatic logic [4:0] log_to_dwords(input logic [2:0] lg);
    return 5'd1 << lg;
  endfunction

  // byte offset of an address inside a line of 2**lg dwords
  function automatic logic [5:0] line_offset(input logic [5:0] low, input logic [2:0] lg);
    logic [5:0] mask;
    mask = 6'((7'd4 << lg) - 7'd1);
    return low & mask;
  endfunction

  function automatic logic [4:0] step_dwords(input logic aligned, input logic boundary,
                                             input logic [2:0] line_lg, input logic [2:0] max_lg,
                                             input logic [31:0] rem);
    logic [4:0] lim;
    if (!aligned)      lim = log_to_dwords(max_lg);
    else if (boundary) lim = log_to_dwords(line_lg);
    else               lim = 5'd1;
    return (rem < {27'd0, lim}) ? rem[4:0] : lim;
  endfunction

  function automatic rd_cmd_e choose_rd(input logic active, input logic aligned, input logic boundary,
                                        input logic [4:0] n, input logic [4:0] line_dw,
                                        input logic en_line, input logic en_multi);
    if (!active) return RD_NONE;
    if (aligned && boundary && (n == line_dw) && en_line) return RD_LINE;
    if ((n > 5'd1) && en_multi) return RD_MULTI;
    return RD_PLAIN;
  endfunction

  function automatic wr_cmd_e choose_wr(input logic active, input logic aligned, input logic boundary,
                                        input logic [4:0] n, input logic [4:0] line_dw,
                                        input logic en_inval);
    if (!active) return WR_NONE;
    if (aligned && boundary && (n == line_dw) && en_inval) return WR_INVAL;
    return WR_PLAIN;
  endfunction

endpackage

// File: rtl/line_size_sel.sv
module line_size_sel
  import burst_align_pkg::*;
(
  input  logic [7:0] cfg,
  input  logic [1:0] sel,
  output logic [2:0] eff_log,
  output logic [2:0] max_log
);
  always_comb begin
    eff_log = effective_log(cfg, sel);
    max_log = burst_log(sel);
  end
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker #(
  parameter int ADDR_W = 32,
  parameter int DW_W   = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [ADDR_W-1:0] init_dst,
  input  logic [DW_W-1:0]   init_dw,
  input  logic              init_align,
  input  logic [2:0]        init_line_log,
  input  logic [2:0]        init_max_log,
  input  logic              init_move,
  input  logic              init_write,
  input  logic              init_en_line,
  input  logic              init_en_multi,
  input  logic              init_en_inval,
  input  logic              fire,
  input  logic [4:0]        step_dw,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [DW_W-1:0]   rem_dw,
  output logic              align_q,
  output logic [2:0]        line_log_q,
  output logic [2:0]        max_log_q,
  output logic              move_q,
  output logic              write_q,
  output logic              en_line_q,
  output logic              en_multi_q,
  output logic              en_inval_q
);
  localparam int STEP_B_W = 7;

  logic [STEP_B_W-1:0] step_bytes;
  logic                last_step;

  assign step_bytes = {step_dw, 2'b00};
  assign last_step  = (rem_dw == DW_W'(step_dw));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      cur_addr   <= '0;
      cur_dst    <= '0;
      rem_dw     <= '0;
      align_q    <= 1'b0;
      line_log_q <= 3'd0;
      max_log_q  <= 3'd0;
      move_q     <= 1'b0;
      write_q    <= 1'b0;
      en_line_q  <= 1'b0;
      en_multi_q <= 1'b0;
      en_inval_q <= 1'b0;
    end else if (take) begin
      busy       <= (init_dw != '0);
      cur_addr   <= init_addr;
      cur_dst    <= init_dst;
      rem_dw     <= init_dw;
      align_q    <= init_align;
      line_log_q <= init_line_log;
      max_log_q  <= init_max_log;
      move_q     <= init_move;
      write_q    <= init_write;
      en_line_q  <= init_en_line;
      en_multi_q <= init_en_multi;
      en_inval_q <= init_en_inval;
    end else if (fire) begin
      cur_addr <= cur_addr + ADDR_W'(step_bytes);
      cur_dst  <= cur_dst + ADDR_W'(step_bytes);
      rem_dw   <= rem_dw - DW_W'(step_dw);
      if (last_step) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/step_sizer.sv
module step_sizer
  import burst_align_pkg::*;
#(
  parameter int DW_W = 14
) (
  input  logic            busy,
  input  logic [5:0]      addr_low,
  input  logic            align_q,
  input  logic [2:0]      line_log_q,
  input  logic [2:0]      max_log_q,
  input  logic [DW_W-1:0] rem_dw,
  input  logic            move_q,
  input  logic            write_q,
  input  logic            en_line_q,
  input  logic            en_multi_q,
  input  logic            en_inval_q,
  output logic            at_boundary,
  output logic [4:0]      line_dw,
  output logic [4:0]      n_dw,
  output rd_cmd_e         rd_cmd,
  output wr_cmd_e         wr_cmd
);
  logic [4:0] n_raw;
  logic       rd_side;
  logic       wr_side;

  always_comb begin
    at_boundary = (line_offset(addr_low, line_log_q) == 6'd0);
    line_dw     = log_to_dwords(line_log_q);
    n_raw       = step_dwords(align_q, at_boundary, line_log_q, max_log_q, 32'(rem_dw));
    n_dw        = busy ? n_raw : 5'd0;
    rd_side     = busy && (move_q || !write_q);
    wr_side     = busy && (move_q || write_q);
    rd_cmd      = choose_rd(rd_side, align_q, at_boundary, n_raw, line_dw, en_line_q, en_multi_q);
    wr_cmd      = choose_wr(wr_side, align_q, at_boundary, n_raw, line_dw, en_inval_q);
  end
endmodule

// File: rtl/burst_align_ctrl.sv
module burst_align_ctrl
  import burst_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        line_size_cfg,
  input  logic [1:0]        max_burst_sel,
  input  logic              en_line_read,
  input  logic              en_multi_read,
  input  logic              en_write_inval,
  input  logic              start,
  input  logic              start_move,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              xfer_done,
  output logic              req_valid,
  output logic [4:0]        req_dwords,
  output logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W-1:0] req_dst_addr,
  output logic [1:0]        req_rd_cmd,
  output logic [1:0]        req_wr_cmd,
  output logic              align_mode
);
  localparam int DW_W = CNT_W - 2;

  // configuration at start
  logic [2:0]      start_eff_log;
  logic [2:0]      start_max_log;
  logic [5:0]      src_off;
  logic [5:0]      dst_off;
  logic            offsets_match;
  logic            start_align;
  logic            take;
  logic [DW_W-1:0] start_dw;

  // running state and named events
  logic            busy;
  logic [DW_W-1:0] rem_dw;
  logic            align_q;
  logic [2:0]      line_log_q;
  logic [2:0]      max_log_q;
  logic            move_q;
  logic            write_q;
  logic            en_line_q;
  logic            en_multi_q;
  logic            en_inval_q;
  logic            at_boundary;
  logic [4:0]      line_dw;
  logic [4:0]      n_dw;
  logic            fire;
  rd_cmd_e         rd_cmd;
  wr_cmd_e         wr_cmd;

  line_size_sel u_size (
    .cfg     (line_size_cfg),
    .sel     (max_burst_sel),
    .eff_log (start_eff_log),
    .max_log (start_max_log)
  );

  assign src_off       = line_offset(src_addr[5:0], start_eff_log);
  assign dst_off       = line_offset(dst_addr[5:0], start_eff_log);
  assign offsets_match = (src_off == dst_off);
  assign start_align   = !start_move || offsets_match;
  assign take          = start && !busy;
  assign start_dw      = byte_count[CNT_W-1:2];
  assign fire          = busy && xfer_done;

  xfer_tracker #(.ADDR_W(ADDR_W), .DW_W(DW_W)) u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .take          (take),
    .init_addr     (src_addr),
    .init_dst      (dst_addr),
    .init_dw       (start_dw),
    .init_align    (start_align),
    .init_line_log (start_eff_log),
    .init_max_log  (start_max_log),
    .init_move     (start_move),
    .init_write    (start_write),
    .init_en_line  (en_line_read),
    .init_en_multi (en_multi_read),
    .init_en_inval (en_write_inval),
    .fire          (fire),
    .step_dw       (n_dw),
    .busy          (busy),
    .cur_addr      (req_addr),
    .cur_dst       (req_dst_addr),
    .rem_dw        (rem_dw),
    .align_q       (align_q),
    .line_log_q    (line_log_q),
    .max_log_q     (max_log_q),
    .move_q        (move_q),
    .write_q       (write_q),
    .en_line_q     (en_line_q),
    .en_multi_q    (en_multi_q),
    .en_inval_q    (en_inval_q)
  );

  step_sizer #(.DW_W(DW_W)) u_step (
    .busy        (busy),
    .addr_low    (req_addr[5:0]),
    .align_q     (align_q),
    .line_log_q  (line_log_q),
    .max_log_q   (max_log_q),
    .rem_dw      (rem_dw),
    .move_q      (move_q),
    .write_q     (write_q),
    .en_line_q   (en_line_q),
    .en_multi_q  (en_multi_q),
    .en_inval_q  (en_inval_q),
    .at_boundary (at_boundary),
    .line_dw     (line_dw),
    .n_dw        (n_dw),
    .rd_cmd      (rd_cmd),
    .wr_cmd      (wr_cmd)
  );

  assign req_valid  = busy;
  assign req_dwords = n_dw;
  assign req_rd_cmd = rd_cmd;
  assign req_wr_cmd = wr_cmd;
  assign align_mode = align_q;

endmodule

// File: rtl/burst_align_chk.sv
module burst_align_chk
  import burst_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DW_W   = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_done,
  input logic              fire,
  input logic              req_valid,
  input logic [4:0]        req_dwords,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_rd_cmd,
  input logic [1:0]        req_wr_cmd,
  input logic              align_mode,
  input logic              at_boundary,
  input logic [4:0]        line_dw,
  input logic [DW_W-1:0]   rem_dw
);
  // R7
  dwords_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_dwords != 5'd0) && (32'(req_dwords) <= 32'(rem_dw)));

  // R3
  single_off_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && align_mode && !at_boundary) |-> (req_dwords == 5'd1));

  // R4
  line_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && align_mode) |-> (req_dwords <= line_dw));

  // R9
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !xfer_done) |=> ($stable(req_dwords) && $stable(req_addr) && $stable(align_mode)));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (req_addr == $past(req_addr) + ADDR_W'({$past(req_dwords), 2'b00})));

  // R10
  line_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd_cmd == RD_LINE) |-> (align_mode && at_boundary && (req_dwords == line_dw)));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> ((req_dwords == 5'd0) && (req_rd_cmd == RD_NONE) && (req_wr_cmd == WR_NONE)));
endmodule

bind burst_align_ctrl burst_align_chk #(.ADDR_W(ADDR_W), .DW_W(DW_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xfer_done   (xfer_done),
  .fire        (fire),
  .req_valid   (req_valid),
  .req_dwords  (req_dwords),
  .req_addr    (req_addr),
  .req_rd_cmd  (req_rd_cmd),
  .req_wr_cmd  (req_wr_cmd),
  .align_mode  (align_mode),
  .at_boundary (at_boundary),
  .line_dw     (line_dw),
  .rem_dw      (rem_dw)
);

// File: tb/tb_burst_align_ctrl.sv
module tb_burst_align_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [7:0]        line_size_cfg = '0;
  logic [1:0]        max_burst_sel = '0;
  logic              en_line_read = 1'b0, en_multi_read = 1'b0, en_write_inval = 1'b0;
  logic              start = 1'b0, start_move = 1'b0, start_write = 1'b0;
  logic [ADDR_W-1:0] src_addr = '0, dst_addr = '0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic              xfer_done = 1'b0;
  logic              req_valid;
  logic [4:0]        req_dwords;
  logic [ADDR_W-1:0] req_addr, req_dst_addr;
  logic [1:0]        req_rd_cmd, req_wr_cmd;
  logic              align_mode;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  burst_align_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // line size in dwords, found by halving from the top
  function automatic int exp_line(input int cfg, input int sel);
    int maxd = 2 << sel;
    int r = 16;
    if (cfg == 0) return maxd;
    while (r > cfg && r > 2) r = r / 2;
    return (r < maxd) ? r : maxd;
  endfunction

  task automatic run_xfer(input int cfg, input int sel, input longint a0, input longint b0,
                          input int bytes, input bit mv, input bit wr,
                          input bit enl, input bit enm, input bit eni, input bit poke);
    int line = exp_line(cfg, sel);
    int maxd = 2 << sel;
    int lb = line * 4;
    longint a = a0, b = b0;
    int rem = bytes / 4;
    bit al = !mv || ((a % lb) == (b % lb));
    bit poked = 0;
    @(negedge clk);
    line_size_cfg = 8'(cfg); max_burst_sel = 2'(sel);
    en_line_read = enl; en_multi_read = enm; en_write_inval = eni;
    start_move = mv; start_write = wr;
    src_addr = a0[31:0]; dst_addr = b0[31:0]; byte_count = 16'(bytes);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (rem > 0) begin
      bit bnd = ((a % lb) == 0);
      int n = !al ? maxd : (bnd ? line : 1);
      int erd, ewr;
      if (n > rem) n = rem;
      if (wr && !mv) erd = 0;
      else if (al && bnd && n == line && enl) erd = 2;
      else if (n > 1 && enm) erd = 3;
      else erd = 1;
      if (!wr && !mv) ewr = 0;
      else if (al && bnd && n == line && eni) ewr = 2;
      else ewr = 1;
      for (int k = 0; k <= $urandom_range(0, 1); k++) begin
        chk(req_valid == 1'b1, "R7 valid", req_valid, 1);
        chk(req_dwords == 5'(n), "R1 R2 R3 R4 R5 R7 dwords", req_dwords, n);
        chk(align_mode == al, "R5 R6 align", align_mode, al);
        chk(req_addr == a[31:0], "R8 addr", req_addr, a[31:0]);
        chk(req_dst_addr == b[31:0], "R8 dst", req_dst_addr, b[31:0]);
        chk(req_rd_cmd == 2'(erd), "R10 rdcmd", req_rd_cmd, erd);
        chk(req_wr_cmd == 2'(ewr), "R11 wrcmd", req_wr_cmd, ewr);
        if (poke && !poked) begin
          poked = 1;
          start = 1'b1; start_move = ~mv; byte_count = 16'h0040;
          src_addr = 32'h0000_0ff0; line_size_cfg = 8'd2; max_burst_sel = 2'(sel ^ 1);
          @(negedge clk);
          start = 1'b0;
          chk(req_dwords == 5'(n), "R9 ignored start dwords", req_dwords, n);
          chk(req_addr == a[31:0], "R9 ignored start addr", req_addr, a[31:0]);
          chk(align_mode == al, "R9 ignored start align", align_mode, al);
        end
        @(negedge clk);
      end
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      a = (a + 4 * n) & 64'hFFFF_FFFF;
      b = (b + 4 * n) & 64'hFFFF_FFFF;
      rem -= n;
    end
    chk(req_valid == 1'b0, "R7 end valid", req_valid, 0);
    chk(req_dwords == 5'd0, "R12 idle dwords", req_dwords, 0);
    chk(req_rd_cmd == 2'd0 && req_wr_cmd == 2'd0, "R12 idle cmds", {req_rd_cmd, req_wr_cmd}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(req_valid == 1'b0, "R12 reset valid", req_valid, 0);
    chk(req_dwords == 5'd0, "R12 reset dwords", req_dwords, 0);
    chk(align_mode == 1'b0, "R12 reset align", align_mode, 0);
    chk(req_rd_cmd == 2'd0 && req_wr_cmd == 2'd0, "R12 reset cmds", {req_rd_cmd, req_wr_cmd}, 0);
    rst_n = 1'b1;

    // R2: zero setting uses max burst 8
    run_xfer(0, 2, 32'h100, 0, 64, 0, 0, 1, 1, 1, 0);
    // R1 R3 R4: setting 12 -> 8, max 16, misaligned start then lines then tail
    run_xfer(12, 3, 32'h1008, 0, 80, 0, 1, 1, 1, 1, 0);
    // R1: setting 32 -> 16 capped by max 4
    run_xfer(32, 1, 32'h2000, 0, 40, 0, 0, 1, 0, 0, 0);
    // R1: setting 1 counts as 2
    run_xfer(1, 3, 32'h3004, 0, 24, 0, 0, 0, 1, 0, 0);
    // R5: unequal move offsets, line 8
    run_xfer(8, 3, 32'h21F, 32'h42F, 100, 1, 0, 1, 1, 1, 0);
    // R5: equal move offsets
    run_xfer(8, 3, 32'h204, 32'h1404, 100, 1, 0, 1, 1, 1, 0);
    // R7: zero length raises nothing
    run_xfer(4, 2, 32'h500, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7: length not a whole line
    run_xfer(16, 3, 32'h600, 0, 12, 0, 1, 0, 0, 1, 0);
    // R9: start while busy
    run_xfer(8, 2, 32'h700, 0, 96, 0, 0, 1, 1, 0, 1);

    for (int t = 0; t < 40; t++) begin
      int cfg = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, 255));
      int sel = $urandom_range(0, 3);
      longint a = longint'($urandom);
      longint b = longint'($urandom);
      bit mv = ($urandom_range(0, 9) < 3);
      if ($urandom_range(0, 1) == 1) a = a & 64'hFFFF_FFFC;
      if (mv && $urandom_range(0, 1) == 1) b = (b & 64'hFFFF_FFC0) | (a & 64'h3F);
      run_xfer(cfg, sel, a, b, 4 * $urandom_range(0, 40), mv, 1'($urandom_range(0, 1)),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               ($urandom_range(0, 4) == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule